// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Counter

This block is an 8-bit up-counting timer that raises an interrupt for a cartridge bank-switching controller. It advances once per CPU clock. Software programs it through four byte-wide registers, chosen by a 2-bit selector on a single write port:

- two registers load the reload value one nibble at a time;
- one register holds the control byte;
- one register acknowledges the interrupt.

The block drives a level-sensitive interrupt request. Address decoding that selects these registers is done outside the block.

There are two counting modes. In cycle mode the counter steps on every enabled clock. In scanline mode a dot prescaler approximates one step per video line. The prescaler starts at 341, loses 3 dots per CPU clock, and gives a step whenever it reaches zero or below. It then gets 341 dots back, so the remainder carries into the next line. When the counter passes 0xFF it reloads from the reload value instead of wrapping to zero, and the interrupt request is set.

Top module: `sirq_timer`

## Requirements
- R1: After reset, irq is low, the control byte is 0x00 (counting off), and the reload value and counter are 0x00. With no writes, irq stays low.
- R2: A write with selector 0 puts wr_data[3:0] into bits 3:0 of the reload value. A write with selector 1 puts wr_data[3:0] into bits 7:4. Each of these writes leaves the other nibble unchanged.
- R3: A write with selector 2 stores wr_data as the control byte, with bit 0 = ack-enable, bit 1 = enable and bit 2 = cycle mode. If bit 1 of the written byte is 1, the counter is loaded with the reload value and the prescaler with 341. The write always drops irq on the next clock.
- R4: A write with selector 3 copies control bit 0 into control bit 1, leaves the other control bits unchanged, and drops irq on the next clock. The written data is ignored.
- R5: With enable = 1 and cycle mode = 1, the counter steps once per clock and the prescaler holds.
- R6: With enable = 1 and cycle mode = 0, the prescaler drops by 3 each clock. A step happens when the result is 0 or below, and 341 is then added to that result. From a fresh load the steps come 114, 114 and then 113 clocks apart.
- R7: A step adds one to the counter. A step from 0xFF loads the counter with the reload value held before that clock and sets irq. Counting from a loaded value L, irq rises on the (256 − L)-th step.
- R8: Once set, irq stays high until a selector 2 or 3 write, or reset. Writes with selector 0 or 1 do not clear it. During a clock that carries a selector 2 or 3 write, no step happens and the prescaler does not move, so the write wins.
- R9: While enable = 0, the counter and the prescaler keep their values. Re-enabling through selector 3 therefore resumes the interrupted line where it stopped.
- R10: Under any random mix of writes and counting, irq matches the behaviour given by R1 to R9 on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; one prescaler/counter step opportunity per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Register select: 0 reload low nibble, 1 reload high nibble, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data byte |
| irq | output | 1 | Level interrupt request |

## Verification
A counter step and an acknowledge or control write can fall in the same clock. The write must win: the interrupt stays low and the step is lost. The bench provokes this by running cycle mode with a reload value of 0xFF, so every clock overflows, and then acknowledging on the very next clock. It expects irq low right after the write and high again one clock later. The same collision happens many times over in the random phase, where a bench model that applies the write-wins rule is compared with irq on every clock.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;

    localparam int DATA_W        = 8;
    localparam int DOTS_PER_LINE = 341;
    localparam int DOTS_PER_CPU  = 3;
    localparam int PRESCALE_W    = 10;

    typedef enum logic [1:0] {
        SEL_RELOAD_LO = 2'd0,
        SEL_RELOAD_HI = 2'd1,
        SEL_CTRL      = 2'd2,
        SEL_ACK       = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [4:0] spare;
        logic       cyc_mode;
        logic       enable;
        logic       ack_en;
    } ctrl_t;

    typedef struct packed {
        logic reload_lo;
        logic reload_hi;
        logic ctrl;
        logic ack;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input reg_sel_e sel);
        wr_strobe_t s;
        s = '0;
        if (en) begin
            unique case (sel)
                SEL_RELOAD_LO: s.reload_lo = 1'b1;
                SEL_RELOAD_HI: s.reload_hi = 1'b1;
                SEL_CTRL:      s.ctrl      = 1'b1;
                SEL_ACK:       s.ack       = 1'b1;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/sirq_regs.sv
`timescale 1ns/1ps
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_strobe_t    stb,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] reload,
    output ctrl_t         ctrl
);
    localparam int NIB = DW / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            ctrl   <= '0;
        end else begin
            if (stb.reload_lo) reload[NIB-1:0]  <= data[NIB-1:0];
            if (stb.reload_hi) reload[DW-1:NIB] <= data[NIB-1:0];
            if (stb.ctrl)      ctrl             <= ctrl_t'(data);
            if (stb.ack)       ctrl.enable      <= ctrl.ack_en;
        end
    end

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        stb.reload_lo |=> reload[DW-1:NIB] == $past(reload[DW-1:NIB])); // R2
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        stb.reload_hi |=> reload[NIB-1:0] == $past(reload[NIB-1:0])); // R2
    AST_ACK_COPY: assert property (@(posedge clk) disable iff (rst)
        stb.ack |=> ctrl.enable == $past(ctrl.ack_en)); // R4
    AST_ACK_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        stb.ack |=> ctrl.cyc_mode == $past(ctrl.cyc_mode) && ctrl.ack_en == $past(ctrl.ack_en)); // R4

endmodule

// File: rtl/sirq_prescaler.sv
`timescale 1ns/1ps
module sirq_prescaler
    import sirq_pkg::*;
#(
    parameter int PW     = PRESCALE_W,
    parameter int PERIOD = DOTS_PER_LINE,
    parameter int STEP   = DOTS_PER_CPU
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic cyc_mode,
    output logic tick
);
    localparam logic [PW-1:0] PERIOD_V = PW'(PERIOD);
    localparam logic [PW-1:0] STEP_V   = PW'(STEP);

    logic [PW-1:0] dots;
    logic [PW-1:0] dots_less;
    logic          line_done;

    always_comb begin
        dots_less = dots - STEP_V;
        line_done = dots_less[PW-1] | (dots_less == '0);
        tick      = run & (cyc_mode | line_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dots <= PERIOD_V;
        end else if (load) begin
            dots <= PERIOD_V;
        end else if (run && !cyc_mode) begin
            dots <= line_done ? dots_less + PERIOD_V : dots_less;
        end
    end

    AST_PRE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> dots == PERIOD_V); // R3
    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load && !run |=> $stable(dots)); // R9
    AST_PRE_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
        run && cyc_mode && !load |=> $stable(dots)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !dots[PW-1] && dots != '0 && dots <= PERIOD_V); // R6

endmodule

// File: rtl/sirq_counter.sv
`timescale 1ns/1ps
module sirq_counter
    import sirq_pkg::*;
#(
    parameter int CW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] reload,
    input  logic          tick,
    input  logic          clr,
    output logic          irq
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] count;
    logic          at_top;

    assign at_top = (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            if (load) begin
                count <= reload;
            end else if (tick) begin
                count <= at_top ? reload : count + 1'b1;
            end
            if (clr) begin
                irq <= 1'b0;
            end else if (tick && at_top) begin
                irq <= 1'b1;
            end
        end
    end

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tick && !load && count == TOP |=> count == $past(reload) && irq); // R7
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        tick && !load && count != TOP |=> count == CW'($past(count) + 1'b1)); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        irq && !clr |=> irq); // R8
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq); // R8
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(reload)); // R3
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick && !load |=> $stable(count)); // R9

endmodule

// File: rtl/sirq_timer.sv
`timescale 1ns/1ps
module sirq_timer
    import sirq_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int PW     = PRESCALE_W,
    parameter int PERIOD = DOTS_PER_LINE,
    parameter int STEP   = DOTS_PER_CPU
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          irq
);
    wr_strobe_t    stb;
    ctrl_t         ctrl;
    ctrl_t         ctrl_wr;
    logic [DW-1:0] reload;
    logic          command;
    logic          load;
    logic          run;
    logic          tick;
    logic          unused_spare;

    always_comb begin
        stb     = decode_write(wr_en, reg_sel_e'(wr_sel));
        ctrl_wr = ctrl_t'(wr_data);
        command = stb.ctrl | stb.ack;
        load    = stb.ctrl & ctrl_wr.enable;
        run     = ctrl.enable & ~command;
    end

    assign unused_spare = ^{ctrl.spare, ctrl_wr.spare, ctrl_wr.cyc_mode, ctrl_wr.ack_en};

    sirq_regs #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .data   (wr_data),
        .reload (reload),
        .ctrl   (ctrl)
    );

    sirq_prescaler #(.PW(PW), .PERIOD(PERIOD), .STEP(STEP)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .run      (run),
        .cyc_mode (ctrl.cyc_mode),
        .tick     (tick)
    );

    sirq_counter #(.CW(DW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .reload (reload),
        .tick   (tick),
        .clr    (command),
        .irq    (irq)
    );

    AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> !$rose(irq)); // R9

endmodule

// File: tb/sim_sirq_timer.sv
`timescale 1ns/1ps
module sim_sirq_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq;

    always #2.5 clk = ~clk;

    sirq_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // Reference model, built from the requirements
    int   m_reload, m_ctrl, m_cnt, m_pre;
    bit   m_irq;

    function automatic int step_pre(int pre);
        return pre - 3;
    endfunction

    always @(posedge clk) begin
        int  old_reload;
        bit  t;
        old_reload = m_reload;
        if (rst) begin
            m_reload = 0; m_ctrl = 0; m_cnt = 0; m_pre = 341; m_irq = 1'b0;
        end else begin
            t = 1'b0;
            if (!(wr_en && wr_sel >= 2'd2) && m_ctrl[1]) begin
                if (m_ctrl[2]) t = 1'b1;
                else begin
                    m_pre = step_pre(m_pre);
                    if (m_pre <= 0) begin t = 1'b1; m_pre = m_pre + 341; end
                end
            end
            if (t) begin
                if (m_cnt == 255) begin m_cnt = old_reload; m_irq = 1'b1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_reload = (m_reload & 8'hF0) | int'(wr_data[3:0]);
                    2'd1: m_reload = (m_reload & 8'h0F) | (int'(wr_data[3:0]) << 4);
                    2'd2: begin
                        m_ctrl = int'(wr_data);
                        if (wr_data[1]) begin m_cnt = old_reload; m_pre = 341; end
                        m_irq = 1'b0;
                    end
                    default: begin
                        m_ctrl = (m_ctrl & ~2) | ((m_ctrl & 1) << 1);
                        m_irq = 1'b0;
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison with the model (R10)
    always @(negedge clk) begin
        if (!rst && !done)
            chk(irq == m_irq, "R10", "irq vs model", int'(irq), int'(m_irq));
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(4);
        chk(irq == 1'b0, "R1", "irq during reset", int'(irq), 0);
        rst = 1'b0;
        idle(1);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        idle(400);
        chk(irq == 1'b0, "R1", "irq with counting off", int'(irq), 0);

        // R2 R5 R7: reload 0xE5 built from nibbles, cycle mode
        wr(2'd0, 8'h35);
        wr(2'd1, 8'hFE);
        wr(2'd2, 8'h06);
        idle(26);
        chk(irq == 1'b0, "R7", "before step 27 from 0xE5", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R5", "rise at step 27 from 0xE5", int'(irq), 1);

        // R8: irq holds, reload writes do not clear it
        idle(100);
        chk(irq == 1'b1, "R8", "irq held", int'(irq), 1);
        wr(2'd0, 8'hFB);
        chk(irq == 1'b1, "R8", "irq after reload write", int'(irq), 1);

        // R3: control write clears and reloads 0xEB
        wr(2'd2, 8'h06);
        chk(irq == 1'b0, "R3", "irq cleared by control write", int'(irq), 0);
        idle(20);
        chk(irq == 1'b0, "R2", "before step 21 from 0xEB", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R2", "rise at step 21 from 0xEB", int'(irq), 1);

        // R2: high nibble write keeps low nibble (0x1B -> 229 steps)
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h06);
        idle(228);
        chk(irq == 1'b0, "R2", "before step 229 from 0x1B", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R2", "rise at step 229 from 0x1B", int'(irq), 1);

        // R8 R4: ack collides with an overflow step, write wins
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h07);
        idle(1);
        chk(irq == 1'b1, "R7", "overflow from 0xFF", int'(irq), 1);
        wr(2'd3, 8'h00);
        chk(irq == 1'b0, "R8", "ack beats same-cycle step", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R4", "ack kept enable, next step", int'(irq), 1);

        // R6: scanline mode, periods 114, 114, 113
        wr(2'd2, 8'h03);
        idle(113);
        chk(irq == 1'b0, "R6", "line 1 before 114", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R6", "line 1 at 114", int'(irq), 1);
        wr(2'd3, 8'h00);
        idle(113);
        chk(irq == 1'b0, "R6", "line 2 before 114", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R6", "line 2 at 114", int'(irq), 1);
        wr(2'd3, 8'h00);
        idle(112);
        chk(irq == 1'b0, "R6", "line 3 before 113", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R6", "line 3 at 113 (carry)", int'(irq), 1);

        // R9 R4: pause mid-line through ack, resume without reload
        wr(2'd2, 8'h02);
        idle(50);
        wr(2'd3, 8'h00);
        idle(200);
        chk(irq == 1'b0, "R9", "paused, no step", int'(irq), 0);
        wr(2'd2, 8'h01);
        idle(30);
        chk(irq == 1'b0, "R3", "control write without enable", int'(irq), 0);
        wr(2'd3, 8'h00);
        idle(63);
        chk(irq == 1'b0, "R9", "resumed line before 64", int'(irq), 0);
        idle(1);
        chk(irq == 1'b1, "R9", "resumed line at 64", int'(irq), 1);

        // R10: random writes mixed with counting
        for (int i = 0; i < 30000; i++) begin
            int r;
            r = $urandom_range(99);
            if (r < 3) begin
                wr_en   = 1'b1;
                wr_sel  = 2'($urandom_range(3));
                wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        idle(2);
        finish_run();
    end

endmodule